// File: doc/BRIEF.md
# Sampling Clock Tap Unit Sequencer

This block runs the short register-level programs that prepare, reset and poll the tap unit. That unit sets the sampling-clock phase for a high-speed SD host. A command port accepts one of three operations. The setup operation programs the unit and returns the tap count the unit reports. The reset operation returns the unit to its plain clock path. The poll operation reports whether an automatic retune error is pending and clears it. The block does not choose a tap and does not model the delay line.

The block issues at most one register access per cycle on a simple bus toward the tap unit. Read data must be valid in the same cycle as the read request. The block also owns the host's card-clock-enable level. It gates the card clock off around every change to the clock-select bit, and it leaves auto-retune disabled after setup and after reset.

The command port uses valid/ready. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a program runs, so the source must hold its command until it is taken. The results `tap_count` and `retune_err` are plain levels. They are valid from the `done` pulse onward and hold until the next command is taken.

Top module: `tune_seq`

## Requirements
- R1: After reset, `busy`, `done`, `reg_req`, `host_stat_clr` and `retune_err` are 0. `card_clk_en` and `cmd_ready` are 1, and `tap_count` is 0.
- R2: The tap unit has six registers, numbered 0 to 5: delay control (0), tap set (1), flop position (2), clock select (3), retune control (4) and retune request (5). Register n sits at word offset 2n, and `reg_addr` carries (2n) << BUS_SHIFT.
- R3: Setup (`cmd_op`=0) takes 12 cycles, one step per cycle, in this order: write delay control; pulse `host_stat_clr`; read delay control; write delay control; card clock off; read clock select; write clock select; card clock on; read retune control; write retune control; write flop position; read delay control.
- R4: Setup writes these values. The first delay-control write is TAP_RANGE in bits 23:16. The second sets bit 0 (tap enable) on the value read back. Clock select gets its read value with bit 0 set. Retune control gets its read value with bit 0 (auto-retune enable) cleared. Flop position gets DFF_POS.
- R5: At the end of setup, `tap_count` equals bits 23:16 of the final delay-control read.
- R6: `card_clk_en` is 0 during every write to clock select, and it is 1 when `done` pulses.
- R7: Reset (`cmd_op`=1) takes 6 cycles: card clock off; read clock select; write it back with bit 0 cleared; card clock on; read retune control; write it back with bit 0 cleared. All other bits are kept.
- R8: Poll (`cmd_op`=2) reads retune control and then retune request. `retune_err` becomes 1 only when retune-control bit 0 and retune-request bit 2 are both set. In that case a third cycle writes 0 to retune request; otherwise the poll ends after two cycles with no write.
- R9: While `busy` is high, `cmd_ready` is 0 and commands have no effect on the running access trace. A command with `cmd_op`=3 is taken but starts nothing: `busy` stays 0 and no access is made.
- R10: `busy` is high for exactly the length of the program. `done` is a single-cycle pulse in the cycle after the last step, when `busy` is already 0.
- R11: `host_stat_clr` pulses exactly once per setup, in its second cycle, and never together with a register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 setup, 1 reset, 2 poll, 3 no operation |
| cmd_ready | output | 1 | Command can be taken (idle) |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| tap_count | output | 8 | Tap count read at end of setup |
| retune_err | output | 1 | Retune error found by the last poll |
| reg_req | output | 1 | Register access this cycle |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | AW | Shifted register offset |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, same cycle as request |
| card_clk_en | output | 1 | Host card clock enable level |
| host_stat_clr | output | 1 | Pulse that clears the host status register |

## Verification
A command is taken on edge E0. Step k of the program is visible on the bus in the cycle after edge E(k), and its write lands at edge E(k+1). A change to `card_clk_en` shows one cycle after its step. `done`, `tap_count` and `retune_err` are due in the cycle after the last step, which is 12, 6, and 2 or 3 cycles after E0. The bench samples every output on the falling edge. It records one trace entry per busy cycle and compares the whole trace and its length against a trace built arithmetically from the preset register values. It then checks the results and the final register contents in the first idle cycle.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int REG_W      = 32;
  localparam int TAPNUM_LSB = 16;
  localparam int TAPNUM_W   = 8;
  localparam int EN_BIT     = 0;
  localparam int ERR_BIT    = 2;

  typedef enum logic [1:0] {
    OP_INIT  = 2'd0,
    OP_RESET = 2'd1,
    OP_CHECK = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    TR_DLY    = 3'd0,
    TR_TAPSET = 3'd1,
    TR_DFF    = 3'd2,
    TR_CKSEL  = 3'd3,
    TR_RTCTL  = 3'd4,
    TR_RTREQ  = 3'd5
  } treg_e;

  typedef enum logic [3:0] {
    U_NOP, U_WR_IMM, U_RD_CAP, U_WR_OR, U_WR_ANDN,
    U_CLK_OFF, U_CLK_ON, U_STAT_CLR, U_RD_TAP, U_RD_EN, U_RD_ERR
  } ukind_e;

  typedef struct packed {
    ukind_e           kind;
    treg_e            rsel;
    logic [REG_W-1:0] imm;
    logic             last;
  } uop_t;

  function automatic uop_t mk_uop(ukind_e k, treg_e r, logic [REG_W-1:0] v, logic l);
    uop_t u;
    u.kind = k;
    u.rsel = r;
    u.imm  = v;
    u.last = l;
    return u;
  endfunction
endpackage

// File: rtl/tune_prog.sv
module tune_prog
  import tune_pkg::*;
#(
  parameter int                TAP_RANGE = 8,
  parameter logic [REG_W-1:0]  DFF_POS   = 32'h0000_0123,
  parameter int                STEP_W    = 4
) (
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  output uop_t              uop
);
  localparam logic [REG_W-1:0] RANGE_WORD = REG_W'(TAP_RANGE) << TAPNUM_LSB;
  localparam logic [REG_W-1:0] EN_MASK    = REG_W'(1) << EN_BIT;

  always_comb begin
    uop = mk_uop(U_NOP, TR_DLY, '0, 1'b1);
    unique case (op)
      OP_INIT: begin
        case (step)
          4'd0:  uop = mk_uop(U_WR_IMM,   TR_DLY,   RANGE_WORD, 1'b0);
          4'd1:  uop = mk_uop(U_STAT_CLR, TR_DLY,   '0,         1'b0);
          4'd2:  uop = mk_uop(U_RD_CAP,   TR_DLY,   '0,         1'b0);
          4'd3:  uop = mk_uop(U_WR_OR,    TR_DLY,   EN_MASK,    1'b0);
          4'd4:  uop = mk_uop(U_CLK_OFF,  TR_DLY,   '0,         1'b0);
          4'd5:  uop = mk_uop(U_RD_CAP,   TR_CKSEL, '0,         1'b0);
          4'd6:  uop = mk_uop(U_WR_OR,    TR_CKSEL, EN_MASK,    1'b0);
          4'd7:  uop = mk_uop(U_CLK_ON,   TR_DLY,   '0,         1'b0);
          4'd8:  uop = mk_uop(U_RD_CAP,   TR_RTCTL, '0,         1'b0);
          4'd9:  uop = mk_uop(U_WR_ANDN,  TR_RTCTL, EN_MASK,    1'b0);
          4'd10: uop = mk_uop(U_WR_IMM,   TR_DFF,   DFF_POS,    1'b0);
          4'd11: uop = mk_uop(U_RD_TAP,   TR_DLY,   '0,         1'b1);
          default: uop = mk_uop(U_NOP,    TR_DLY,   '0,         1'b1);
        endcase
      end
      OP_RESET: begin
        case (step)
          4'd0: uop = mk_uop(U_CLK_OFF, TR_DLY,   '0,      1'b0);
          4'd1: uop = mk_uop(U_RD_CAP,  TR_CKSEL, '0,      1'b0);
          4'd2: uop = mk_uop(U_WR_ANDN, TR_CKSEL, EN_MASK, 1'b0);
          4'd3: uop = mk_uop(U_CLK_ON,  TR_DLY,   '0,      1'b0);
          4'd4: uop = mk_uop(U_RD_CAP,  TR_RTCTL, '0,      1'b0);
          4'd5: uop = mk_uop(U_WR_ANDN, TR_RTCTL, EN_MASK, 1'b1);
          default: uop = mk_uop(U_NOP,  TR_DLY,   '0,      1'b1);
        endcase
      end
      OP_CHECK: begin
        case (step)
          4'd0: uop = mk_uop(U_RD_EN,  TR_RTCTL, '0, 1'b0);
          4'd1: uop = mk_uop(U_RD_ERR, TR_RTREQ, '0, 1'b0);
          4'd2: uop = mk_uop(U_WR_IMM, TR_RTREQ, '0, 1'b1);
          default: uop = mk_uop(U_NOP, TR_DLY,   '0, 1'b1);
        endcase
      end
      default: uop = mk_uop(U_NOP, TR_DLY, '0, 1'b1);
    endcase
  end
endmodule

// File: rtl/tune_bus_if.sv
module tune_bus_if
  import tune_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BUS_SHIFT = 0
) (
  input  logic             busy,
  input  uop_t             uop,
  input  logic [REG_W-1:0] cap,
  output logic             reg_req,
  output logic             reg_we,
  output logic [AW-1:0]    reg_addr,
  output logic [REG_W-1:0] reg_wdata
);
  logic          is_wr;
  logic          is_rd;
  logic [AW-1:0] word_off;

  always_comb begin
    is_wr = 1'b0;
    is_rd = 1'b0;
    unique case (uop.kind)
      U_WR_IMM, U_WR_OR, U_WR_ANDN:         is_wr = 1'b1;
      U_RD_CAP, U_RD_TAP, U_RD_EN, U_RD_ERR: is_rd = 1'b1;
      default: ;
    endcase
  end

  assign word_off = AW'(uop.rsel) << 1;
  assign reg_req  = busy && (is_wr || is_rd);
  assign reg_we   = busy && is_wr;
  assign reg_addr = reg_req ? (word_off << BUS_SHIFT) : '0;

  always_comb begin
    reg_wdata = '0;
    if (reg_we) begin
      unique case (uop.kind)
        U_WR_OR:   reg_wdata = cap | uop.imm;
        U_WR_ANDN: reg_wdata = cap & ~uop.imm;
        default:   reg_wdata = uop.imm;
      endcase
    end
  end
endmodule

// File: rtl/tune_datapath.sv
module tune_datapath
  import tune_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                busy,
  input  uop_t                uop,
  input  logic [REG_W-1:0]    rdata,
  output logic [REG_W-1:0]    cap,
  output logic [TAPNUM_W-1:0] tap_count,
  output logic                retune_err,
  output logic                err_hit
);
  logic en_seen;

  assign err_hit = busy && (uop.kind == U_RD_ERR) && en_seen && rdata[ERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap        <= '0;
      tap_count  <= '0;
      retune_err <= 1'b0;
      en_seen    <= 1'b0;
    end else if (start) begin
      retune_err <= 1'b0;
      en_seen    <= 1'b0;
    end else if (busy) begin
      unique case (uop.kind)
        U_RD_CAP: cap       <= rdata;
        U_RD_TAP: tap_count <= rdata[TAPNUM_LSB +: TAPNUM_W];
        U_RD_EN:  en_seen   <= rdata[EN_BIT];
        U_RD_ERR: if (err_hit) retune_err <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_pkg::*;
#(
  parameter int               AW        = 8,
  parameter int               BUS_SHIFT = 0,
  parameter int               TAP_RANGE = 8,
  parameter logic [REG_W-1:0] DFF_POS   = 32'h0000_0123
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  output logic                cmd_ready,
  output logic                busy,
  output logic                done,
  output logic [TAPNUM_W-1:0] tap_count,
  output logic                retune_err,
  output logic                reg_req,
  output logic                reg_we,
  output logic [AW-1:0]       reg_addr,
  output logic [REG_W-1:0]    reg_wdata,
  input  logic [REG_W-1:0]    reg_rdata,
  output logic                card_clk_en,
  output logic                host_stat_clr
);
  localparam int MAX_STEPS = 12;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  op_e              op_q;
  logic [STEP_W-1:0] step;
  uop_t             uop;
  logic [REG_W-1:0] cap;
  logic             err_hit;
  logic             accept;
  logic             start;
  logic             step_last;

  assign cmd_ready     = !busy;
  assign accept        = cmd_valid && cmd_ready;
  assign start         = accept && (op_e'(cmd_op) != OP_NONE);
  assign step_last     = uop.last || ((uop.kind == U_RD_ERR) && !err_hit);
  assign host_stat_clr = busy && (uop.kind == U_STAT_CLR);

  tune_prog #(
    .TAP_RANGE(TAP_RANGE), .DFF_POS(DFF_POS), .STEP_W(STEP_W)
  ) u_prog (
    .op(op_q), .step(step), .uop(uop)
  );

  tune_bus_if #(.AW(AW), .BUS_SHIFT(BUS_SHIFT)) u_bus (
    .busy(busy), .uop(uop), .cap(cap),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  tune_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .uop(uop),
    .rdata(reg_rdata), .cap(cap), .tap_count(tap_count),
    .retune_err(retune_err), .err_hit(err_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      step        <= '0;
      op_q        <= OP_NONE;
      card_clk_en <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
        op_q <= op_e'(cmd_op);
      end else if (busy) begin
        if (uop.kind == U_CLK_OFF) card_clk_en <= 1'b0;
        if (uop.kind == U_CLK_ON)  card_clk_en <= 1'b1;
        if (step_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk #(
  parameter int AW        = 8,
  parameter int BUS_SHIFT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          busy,
  input logic          done,
  input logic          card_clk_en,
  input logic          reg_req,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          host_stat_clr
);
  localparam logic [AW-1:0] CKSEL_ADDR = AW'(6) << BUS_SHIFT;
  localparam logic [AW-1:0] LOW_MASK   = (AW'(1) << (BUS_SHIFT + 1)) - AW'(1);

  p_cksel_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == CKSEL_ADDR) |-> !card_clk_en);
  p_clk_on_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> card_clk_en);
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> ((reg_addr & LOW_MASK) == '0));
  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fell_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  p_stat_clr_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_stat_clr |-> (busy && !reg_req));
endmodule

bind tune_seq tune_seq_chk #(.AW(AW), .BUS_SHIFT(BUS_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .busy(busy), .done(done),
  .card_clk_en(card_clk_en), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .host_stat_clr(host_stat_clr)
);

// File: tb/tune_seq_bench.sv
module tune_seq_bench;
  localparam int          AW    = 8;
  localparam int          SHIFT = 2;
  localparam int          TAP   = 8;
  localparam logic [31:0] POS   = 32'h0000_0123;
  localparam int          MAXT  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ready, busy, done, retune_err, reg_req, reg_we, card_clk_en, host_stat_clr;
  logic [7:0]  tap_count;
  logic [AW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  tune_seq #(.AW(AW), .BUS_SHIFT(SHIFT), .TAP_RANGE(TAP), .DFF_POS(POS)) u_tune_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .tap_count(tap_count),
    .retune_err(retune_err), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_clk_en(card_clk_en), .host_stat_clr(host_stat_clr)
  );

  // register model of the tap unit
  logic [31:0] regs [6];
  logic [31:0] pre_vals [6];
  logic        pre_go = 1'b0;
  logic [AW-1:0] ridx;
  assign ridx      = reg_addr >> (SHIFT + 1);
  assign reg_rdata = (reg_req && ridx < 6) ? regs[ridx[2:0]] : 32'h0;

  always @(posedge clk) begin
    if (pre_go) begin
      for (int i = 0; i < 6; i++) regs[i] <= pre_vals[i];
    end else if (reg_req && reg_we && ridx < 6) begin
      regs[ridx[2:0]] <= reg_wdata;
    end
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // trace entry: {req, we, idx[2:0], stat, ce, data[31:0]}
  logic [38:0] obs [MAXT];
  logic [38:0] expt [MAXT];
  int n_obs, n_exp;
  logic saw_done;

  function automatic logic [38:0] ent(logic rq, logic w, logic [2:0] ix, logic st, logic ce, logic [31:0] d);
    return {rq, w, ix, st, ce, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic rq, input logic w, input logic [2:0] ix, input logic st,
                      input logic ce, input logic [31:0] d);
    expt[n_exp] = ent(rq, w, ix, st, ce, d);
    n_exp++;
  endtask

  task automatic preset(input logic [31:0] v0, v1, v2, v3, v4, v5);
    @(negedge clk);
    pre_vals[0] = v0; pre_vals[1] = v1; pre_vals[2] = v2;
    pre_vals[3] = v3; pre_vals[4] = v4; pre_vals[5] = v5;
    pre_go = 1'b1;
    @(negedge clk);
    pre_go = 1'b0;
  endtask

  task automatic run(input logic [1:0] op, input bit inject);
    n_obs = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && n_obs < MAXT) begin
      obs[n_obs] = ent(reg_req, reg_we, reg_req ? ridx[2:0] : 3'd0, host_stat_clr, card_clk_en,
                       (reg_req && reg_we) ? reg_wdata : 32'h0);
      n_obs++;
      if (inject && n_obs == 3) begin
        cmd_valid = 1'b1;
        cmd_op    = 2'd1;
      end
      if (n_obs == 6) cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    saw_done  = done;
  endtask

  task automatic cmp_trace(input string req);
    chk(n_obs == n_exp, req, 64'(n_obs), 64'(n_exp));
    chk(saw_done && !busy, {req, " done"}, {62'd0, saw_done, busy}, 64'h2);
    for (int i = 0; i < n_exp && i < n_obs; i++)
      chk(obs[i] == expt[i], req, 64'(obs[i]), 64'(expt[i]));
  endtask

  task automatic build_init(input logic [31:0] c, input logic [31:0] v);
    logic [31:0] rng;
    rng = 32'(TAP) << 16;
    n_exp = 0;
    push(1, 1, 0, 0, 1, rng);
    push(0, 0, 0, 1, 1, 0);
    push(1, 0, 0, 0, 1, 0);
    push(1, 1, 0, 0, 1, rng | 32'h1);
    push(0, 0, 0, 0, 1, 0);
    push(1, 0, 3, 0, 0, 0);
    push(1, 1, 3, 0, 0, c | 32'h1);
    push(0, 0, 0, 0, 0, 0);
    push(1, 0, 4, 0, 1, 0);
    push(1, 1, 4, 0, 1, v & ~32'h1);
    push(1, 1, 2, 0, 1, POS);
    push(1, 0, 0, 0, 1, 0);
  endtask

  initial begin
    logic [31:0] a, c, v, q;
    #1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !reg_req && !host_stat_clr && !retune_err, "R1",
        {59'd0, busy, done, reg_req, host_stat_clr, retune_err}, 64'd0);
    chk(card_clk_en && cmd_ready && tap_count == 8'd0, "R1",
        {54'd0, card_clk_en, cmd_ready, tap_count}, {54'd0, 2'b11, 8'd0});
    rst_n = 1'b1;
    @(negedge clk);

    // setup sweep: R2 R3 R4 R5 R6 R11 R10
    for (int k = 0; k < 8; k++) begin
      a = 32'h9E37_79B9 * (k + 1);
      c = a ^ 32'h5555_0000 ^ 32'(k & 1);
      v = ~a | 32'(k >> 1 & 1);
      preset(a, 32'h0, 32'hFFFF_FFFF, c, v, a ^ 32'hA5);
      build_init(c, v);
      run(2'd0, 1'b0);
      cmp_trace("R3");
      chk(tap_count == 8'(TAP), "R5", 64'(tap_count), 64'(TAP));
      chk(regs[0] == ((32'(TAP) << 16) | 32'h1) && regs[2] == POS, "R4",
          {regs[0], regs[2]}, {(32'(TAP) << 16) | 32'h1, POS});
      chk(regs[3] == (c | 32'h1) && regs[4] == (v & ~32'h1), "R4",
          {regs[3], regs[4]}, {c | 32'h1, v & ~32'h1});
      chk(card_clk_en, "R6", 64'(card_clk_en), 64'd1);
    end

    // reset sweep: R7 R6
    for (int k = 0; k < 8; k++) begin
      c = 32'h1234_5678 * (k + 3) | 32'(k & 1);
      v = 32'h0F0F_0F0F ^ (32'hC3 * k) | 32'(k >> 1 & 1);
      preset(32'h7, 32'h8, 32'h9, c, v, 32'h4);
      n_exp = 0;
      push(0, 0, 0, 0, 1, 0);
      push(1, 0, 3, 0, 0, 0);
      push(1, 1, 3, 0, 0, c & ~32'h1);
      push(0, 0, 0, 0, 0, 0);
      push(1, 0, 4, 0, 1, 0);
      push(1, 1, 4, 0, 1, v & ~32'h1);
      run(2'd1, 1'b0);
      cmp_trace("R7");
      chk(regs[3] == (c & ~32'h1) && regs[4] == (v & ~32'h1), "R7",
          {regs[3], regs[4]}, {c & ~32'h1, v & ~32'h1});
      chk(card_clk_en, "R6", 64'(card_clk_en), 64'd1);
    end

    // poll sweep: R8
    for (int en = 0; en < 2; en++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 3; p++) begin
          v = (32'hDEAD_BEE0 + 32'(p * 6)) & ~32'h1 | 32'(en);
          q = (32'h0000_F0F1 * (p + 1)) & ~32'h4 | (32'(e) << 2);
          preset(32'h0, 32'h0, 32'h0, 32'h0, v, q);
          n_exp = 0;
          push(1, 0, 4, 0, 1, 0);
          push(1, 0, 5, 0, 1, 0);
          if (en == 1 && e == 1) push(1, 1, 5, 0, 1, 32'h0);
          run(2'd2, 1'b0);
          cmp_trace("R8");
          chk(retune_err == (en == 1 && e == 1), "R8", 64'(retune_err), 64'(en == 1 && e == 1));
          chk(regs[5] == ((en == 1 && e == 1) ? 32'h0 : q), "R8",
              64'(regs[5]), 64'((en == 1 && e == 1) ? 32'h0 : q));
        end

    // R9: commands while busy are ignored
    c = 32'h0000_0F00;
    v = 32'h0000_0033;
    preset(32'h0, 32'h0, 32'h0, c, v, 32'h0);
    build_init(c, v);
    run(2'd0, 1'b1);
    cmp_trace("R9");
    @(negedge clk);
    chk(!busy && !reg_req, "R9", {62'd0, busy, reg_req}, 64'd0);

    // R9: no-operation command
    preset(32'h11, 32'h22, 32'h33, 32'h44, 32'h55, 32'h66);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !reg_req && !done, "R9", {61'd0, busy, reg_req, done}, 64'd0);
    @(negedge clk);
    chk(regs[3] == 32'h44 && regs[5] == 32'h66 && card_clk_en, "R9",
        {regs[3], regs[5]}, {32'h44, 32'h66});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule